// File: doc/BRIEF.md
# Interleaved PCM Bus Slot Controller

This block lets two or four framer devices share one serial PCM bus by taking turns on it. Each device owns a turn that lasts one byte or one whole frame of bits. The turn passes from device to device through a carry daisy chain: a device's `carry_out` is wired to the next device's `carry_in`, and the last device feeds the first. One device in the ring is the master. It opens the first turn after reset or enable without waiting for a carry. After that it opens a new turn once per round, where a round is the turn length times the number of devices. The other devices are slaves and start only on a carry edge.

During its own turn the block asserts `rx_oe`, which lets the receive serial data and signaling outputs drive the bus. It also asserts `tx_se`, which lets the transmit-side inputs be sampled. Outside its turn it releases the bus. The block tracks the bit and channel position inside its turn and keeps a sticky flag for carry edges that arrive while a turn is already running. When interleaving is disabled, the block behaves as a device that owns the bus all the time.

Top module: `ibus_slot_ctrl`

## Requirements
- R1: While `ilv_en` is 0, `rx_oe` and `tx_se` are 1, `carry_out` is 0, and `carry_in` activity has no effect on these outputs or on `slot_err`.
- R2: `role_sel[0]` = 1 selects master and 0 selects slave. `role_sel[1]` = 1 selects four devices on the bus and 0 selects two. `ilv_frame` = 0 selects byte turns and 1 selects frame turns.
- R3: A slave starts a turn only on a rising edge of `carry_in`, sampled at a clock edge. `rx_oe` and `tx_se` are 1 from the next cycle on. A `carry_in` that stays high starts only one turn.
- R4: A turn lasts BITS_PER_CHAN consecutive cycles (8) in byte mode and BITS_PER_CHAN*CHANS_PER_FRAME consecutive cycles (256) in frame mode.
- R5: `carry_out` is 1 for exactly one cycle per turn, and that cycle is the last cycle of the turn.
- R6: While enabled and outside its own turn, the block holds `rx_oe` and `tx_se` at 0.
- R7: A master's first turn starts in the first cycle after reset is released, or after `ilv_en` rises. Later turns start every turn length × device-count cycles, with no `carry_in` required.
- R8: A `carry_in` rising edge that arrives during a turn is ignored, so the turn keeps its length. Such an edge sets `slot_err`, which stays 1 until reset.
- R9: During a turn `bit_pos` runs 0..BITS_PER_CHAN-1, one step per cycle. `chan_pos` advances by one at each bit wrap and wraps after CHANS_PER_FRAME-1. In byte mode it therefore advances once per turn, and in frame mode it returns to 0 at the end of the turn.
- R10: Right after reset, `slot_err`, `bit_pos`, `chan_pos` and `carry_out` are 0. With `ilv_en` = 1, `rx_oe` and `tx_se` are also 0, except that a master enabled through reset starts its first turn on the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus bit clock, one bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ilv_en | input | 1 | Interleave enable |
| ilv_frame | input | 1 | 0 selects byte turns, 1 selects frame turns |
| role_sel | input | 2 | Bit 0 selects master, bit 1 selects four devices |
| carry_in | input | 1 | Turn token from the previous device |
| carry_out | output | 1 | One-cycle token to the next device |
| rx_oe | output | 1 | Drive enable for receive data and signaling |
| tx_se | output | 1 | Sample enable for transmit data and signaling |
| slot_err | output | 1 | Sticky flag for a carry edge that arrived during a turn |
| bit_pos | output | BIT_W (3) | Bit index inside the channel |
| chan_pos | output | CHAN_W (5) | Channel index |

## Verification
The bench builds the block with its default parameters: 8 bits per channel, 32 channels, master support present and no carry synchronizer. With these values the full 256-bit frame turn and the 1024-cycle four-device master round are short enough to measure end to end. A table walks all four master configurations, byte and frame at two and four devices, and both slave turn lengths. Directed tests then cover a carry that is held high, a carry that arrives mid-turn, disabled operation, and a master started by enable.

// File: rtl/ibus_pkg.sv
package ibus_pkg;

   localparam int ROLE_MASTER_BIT = 0;
   localparam int ROLE_FOUR_BIT   = 1;

   typedef struct packed {
      logic master;
      logic four;
   } role_t;

   function automatic role_t decode_role(input logic [1:0] sel);
      role_t r;
      r.master = sel[ROLE_MASTER_BIT];
      r.four   = sel[ROLE_FOUR_BIT];
      return r;
   endfunction

endpackage

// File: rtl/ibus_edge_det.sv
module ibus_edge_det #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);

   initial begin
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3)
         $error("ibus_edge_det: SYNC_STAGES must be 0..3");
   end

   logic d_cur;
   logic d_hist;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign d_cur = din;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
         end
         assign d_cur = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) d_hist <= 1'b0;
      else        d_hist <= d_cur;
   end

   assign rise = d_cur & ~d_hist;

endmodule

// File: rtl/ibus_pos_cnt.sv
module ibus_pos_cnt #(
   parameter int BITS_PER_CHAN   = 8,
   parameter int CHANS_PER_FRAME = 32,
   localparam int BIT_W  = $clog2(BITS_PER_CHAN),
   localparam int CHAN_W = $clog2(CHANS_PER_FRAME)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              start,
   input  logic              step,
   input  logic              frame_mode,
   output logic [BIT_W-1:0]  bit_pos,
   output logic [CHAN_W-1:0] chan_pos,
   output logic              last
);

   localparam logic [BIT_W-1:0]  BMAX = BIT_W'(BITS_PER_CHAN - 1);
   localparam logic [CHAN_W-1:0] CMAX = CHAN_W'(CHANS_PER_FRAME - 1);

   initial begin
      if (BITS_PER_CHAN < 2 || CHANS_PER_FRAME < 2)
         $error("ibus_pos_cnt: BITS_PER_CHAN and CHANS_PER_FRAME must be >= 2");
   end

   logic bit_wrap;
   assign bit_wrap = (bit_pos == BMAX);
   assign last     = bit_wrap && (!frame_mode || chan_pos == CMAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_pos  <= '0;
         chan_pos <= '0;
      end else if (clr) begin
         bit_pos  <= '0;
         chan_pos <= '0;
      end else if (start) begin
         bit_pos <= '0;
         if (frame_mode) chan_pos <= '0;
      end else if (step) begin
         if (bit_wrap) begin
            bit_pos  <= '0;
            chan_pos <= (chan_pos == CMAX) ? '0 : chan_pos + 1'b1;
         end else begin
            bit_pos <= bit_pos + 1'b1;
         end
      end
   end

   // R9: bit index wraps to zero after its last value
   a_r9_bit_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && !start && bit_pos == BMAX) |=> (bit_pos == '0));

   // R9: channel index holds while the bit index is not wrapping
   a_r9_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && !start && bit_pos != BMAX) |=> $stable(chan_pos));

endmodule

// File: rtl/ibus_round_timer.sv
module ibus_round_timer #(
   parameter int BITS_PER_CHAN   = 8,
   parameter int CHANS_PER_FRAME = 32,
   parameter bit MASTER_EN       = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic frame_mode,
   input  logic four_dev,
   output logic start
);

   localparam int TL_BYTE = BITS_PER_CHAN;
   localparam int TL_FRM  = BITS_PER_CHAN * CHANS_PER_FRAME;
   localparam int PER_MAX = TL_FRM * 4;
   localparam int RC_W    = $clog2(PER_MAX);

   initial begin
      if (PER_MAX < 4)
         $error("ibus_round_timer: round period too short");
   end

   generate
      if (MASTER_EN) begin : g_master
         localparam logic [RC_W-1:0] END_B2 = RC_W'(TL_BYTE * 2 - 1);
         localparam logic [RC_W-1:0] END_B4 = RC_W'(TL_BYTE * 4 - 1);
         localparam logic [RC_W-1:0] END_F2 = RC_W'(TL_FRM * 2 - 1);
         localparam logic [RC_W-1:0] END_F4 = RC_W'(TL_FRM * 4 - 1);

         logic [RC_W-1:0] rc_q;
         logic [RC_W-1:0] rc_end;

         always_comb begin
            unique case ({frame_mode, four_dev})
               2'b00:   rc_end = END_B2;
               2'b01:   rc_end = END_B4;
               2'b10:   rc_end = END_F2;
               default: rc_end = END_F4;
            endcase
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               rc_q <= '0;
            else if (!run)            rc_q <= '0;
            else if (rc_q >= rc_end)  rc_q <= '0;
            else                      rc_q <= rc_q + 1'b1;
         end

         assign start = run && (rc_q == '0);

         // R7: a start is never followed directly by another start
         a_r7_no_double_start: assert property (@(posedge clk) disable iff (!rst_n)
            start |=> !start);
      end else begin : g_slave_only
         assign start = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/ibus_slot_ctrl.sv
module ibus_slot_ctrl #(
   parameter int BITS_PER_CHAN   = 8,
   parameter int CHANS_PER_FRAME = 32,
   parameter bit MASTER_EN       = 1'b1,
   parameter int CI_SYNC_STAGES  = 0,
   localparam int BIT_W  = $clog2(BITS_PER_CHAN),
   localparam int CHAN_W = $clog2(CHANS_PER_FRAME)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ilv_en,
   input  logic              ilv_frame,
   input  logic [1:0]        role_sel,
   input  logic              carry_in,
   output logic              carry_out,
   output logic              rx_oe,
   output logic              tx_se,
   output logic              slot_err,
   output logic [BIT_W-1:0]  bit_pos,
   output logic [CHAN_W-1:0] chan_pos
);

   import ibus_pkg::*;

   role_t role;
   logic  ci_rise;
   logic  m_start;
   logic  slot_start;
   logic  active_q;
   logic  err_q;
   logic  last_bit;

   assign role = decode_role(role_sel);

   ibus_edge_det #(.SYNC_STAGES(CI_SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (carry_in),
      .rise  (ci_rise)
   );

   ibus_round_timer #(
      .BITS_PER_CHAN   (BITS_PER_CHAN),
      .CHANS_PER_FRAME (CHANS_PER_FRAME),
      .MASTER_EN       (MASTER_EN)
   ) u_round (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (ilv_en && role.master),
      .frame_mode (ilv_frame),
      .four_dev   (role.four),
      .start      (m_start)
   );

   assign slot_start = ilv_en && !active_q &&
                       (role.master ? m_start : ci_rise);

   ibus_pos_cnt #(
      .BITS_PER_CHAN   (BITS_PER_CHAN),
      .CHANS_PER_FRAME (CHANS_PER_FRAME)
   ) u_pos (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (!ilv_en),
      .start      (slot_start),
      .step       (active_q),
      .frame_mode (ilv_frame),
      .bit_pos    (bit_pos),
      .chan_pos   (chan_pos),
      .last       (last_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  active_q <= 1'b0;
      else if (!ilv_en)            active_q <= 1'b0;
      else if (slot_start)         active_q <= 1'b1;
      else if (active_q && last_bit) active_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           err_q <= 1'b0;
      else if (ilv_en && active_q && ci_rise) err_q <= 1'b1;
   end

   assign slot_err  = err_q;
   assign carry_out = ilv_en && active_q && last_bit;
   assign rx_oe     = !ilv_en || active_q;
   assign tx_se     = !ilv_en || active_q;

   // R1: disabled block owns the bus and never passes the token
   a_r1_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !ilv_en |-> (rx_oe && tx_se && !carry_out));

   // R3: a slave carry edge outside a turn opens the bus next cycle
   a_r3_open_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (ilv_en && !role.master && !active_q && ci_rise) |=> rx_oe);

   // R5: carry out only inside the turn, and never two cycles running
   a_r5_co_in_turn: assert property (@(posedge clk) disable iff (!rst_n)
      carry_out |-> (rx_oe && tx_se));
   a_r5_co_single: assert property (@(posedge clk) disable iff (!rst_n)
      carry_out |=> !carry_out);

   // R8: error flag is sticky
   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      slot_err |=> slot_err);

endmodule

// File: tb/tb_ibus_slot_ctrl.sv
module tb_ibus_slot_ctrl;

   localparam int BPC = 8;
   localparam int CPF = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ilv_en = 1'b0;
   logic       ilv_frame = 1'b0;
   logic [1:0] role_sel = 2'b00;
   logic       carry_in = 1'b0;
   logic       carry_out, rx_oe, tx_se, slot_err;
   logic [2:0] bit_pos;
   logic [4:0] chan_pos;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   ibus_slot_ctrl #(
      .BITS_PER_CHAN(BPC), .CHANS_PER_FRAME(CPF),
      .MASTER_EN(1'b1), .CI_SYNC_STAGES(0)
   ) dut (
      .clk(clk), .rst_n(rst_n), .ilv_en(ilv_en), .ilv_frame(ilv_frame),
      .role_sel(role_sel), .carry_in(carry_in), .carry_out(carry_out),
      .rx_oe(rx_oe), .tx_se(tx_se), .slot_err(slot_err),
      .bit_pos(bit_pos), .chan_pos(chan_pos)
   );

   typedef struct packed {
      logic        frame;
      logic [1:0]  role;
      logic [15:0] tl;
      logic [15:0] per;
   } vec_t;

   // role bit0 master, bit1 four devices; per = 0 for slaves
   localparam vec_t VECS [0:5] = '{
      '{1'b0, 2'b01, 16'd8,   16'd16},
      '{1'b0, 2'b11, 16'd8,   16'd32},
      '{1'b1, 2'b01, 16'd256, 16'd512},
      '{1'b1, 2'b11, 16'd256, 16'd1024},
      '{1'b0, 2'b00, 16'd8,   16'd0},
      '{1'b1, 2'b10, 16'd256, 16'd0}
   };

   task automatic check(input int act, input int exp, input string req);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic en, input logic frm, input logic [1:0] rs);
      @(negedge clk);
      rst_n = 1'b0;
      ilv_en = en; ilv_frame = frm; role_sel = rs; carry_in = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_master(input vec_t v);
      int bad_oe = 0, bad_co = 0, bad_se = 0;
      do_reset(1'b1, v.frame, v.role);
      for (int n = 0; n < int'(v.per); n++) begin
         @(negedge clk);
         if (rx_oe !== (n < int'(v.tl))) bad_oe++;
         if (tx_se !== rx_oe) bad_se++;
         if (carry_out !== (n == int'(v.tl) - 1)) bad_co++;
      end
      check(bad_oe, 0, "R4/R7 master turn window");
      check(bad_se, 0, "R6 tx_se tracks rx_oe");
      check(bad_co, 0, "R5 master carry_out position");
      @(negedge clk);
      check(rx_oe, 1, "R7 master next round start");
   endtask

   task automatic run_slave(input vec_t v);
      int bad_oe = 0, bad_co = 0, bad_bit = 0, bad_ch = 0;
      int exp_ch;
      do_reset(1'b1, v.frame, v.role);
      repeat (3) @(negedge clk);
      check(rx_oe, 0, "R6 slave idle rx_oe");
      check(tx_se, 0, "R6 slave idle tx_se");
      carry_in = 1'b1;
      for (int n = 0; n < int'(v.tl) + 3; n++) begin
         @(negedge clk);
         if (n == 0) carry_in = 1'b0;
         if (rx_oe !== (n < int'(v.tl))) bad_oe++;
         if (carry_out !== (n == int'(v.tl) - 1)) bad_co++;
         if (n < int'(v.tl)) begin
            if (int'(bit_pos) != n % BPC) bad_bit++;
            exp_ch = v.frame ? n / BPC : 0;
            if (int'(chan_pos) != exp_ch) bad_ch++;
         end
      end
      check(bad_oe, 0, "R3/R4 slave turn window");
      check(bad_co, 0, "R5 slave carry_out position");
      check(bad_bit, 0, "R9 bit_pos sequence");
      check(bad_ch, 0, "R9 chan_pos during turn");
      check(int'(chan_pos), v.frame ? 0 : 1, "R9 chan_pos after turn");
   endtask

   initial begin : watchdog
      #(4 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      int cnt;
      // R10 reset state, slave enabled
      ilv_en = 1'b1; role_sel = 2'b00;
      repeat (2) @(negedge clk);
      check(rx_oe, 0, "R10 reset rx_oe");
      check(tx_se, 0, "R10 reset tx_se");
      check(carry_out, 0, "R10 reset carry_out");
      check(slot_err, 0, "R10 reset slot_err");
      check(int'(bit_pos), 0, "R10 reset bit_pos");
      check(int'(chan_pos), 0, "R10 reset chan_pos");

      // table of configurations, R2 encodings
      for (int i = 0; i < 6; i++) begin
         if (VECS[i].role[0]) run_master(VECS[i]);
         else                 run_slave(VECS[i]);
      end

      // R3 held-high carry starts one turn only
      do_reset(1'b1, 1'b0, 2'b00);
      carry_in = 1'b1;
      cnt = 0;
      for (int n = 0; n < 30; n++) begin
         @(negedge clk);
         if (carry_out) cnt++;
      end
      carry_in = 1'b0;
      check(cnt, 1, "R3 level carry gives one turn");

      // R8 carry edge during turn
      do_reset(1'b1, 1'b0, 2'b10);
      @(negedge clk);
      carry_in = 1'b1;
      cnt = 0;
      for (int n = 0; n < 12; n++) begin
         @(negedge clk);
         if (n == 0 || n == 4) carry_in = 1'b0;
         if (n == 3) carry_in = 1'b1;
         if (rx_oe !== (n < 8)) cnt++;
      end
      check(cnt, 0, "R8 mid-turn edge keeps turn length");
      check(slot_err, 1, "R8 slot_err set");
      repeat (5) @(negedge clk);
      check(slot_err, 1, "R8 slot_err sticky");

      // R1 disabled
      do_reset(1'b0, 1'b0, 2'b00);
      cnt = 0;
      for (int n = 0; n < 20; n++) begin
         @(negedge clk);
         if (!rx_oe || !tx_se || carry_out || slot_err) cnt++;
         carry_in = (n % 3 == 0);
      end
      carry_in = 1'b0;
      check(cnt, 0, "R1 disabled outputs");

      // R7 master started by enable
      do_reset(1'b0, 1'b0, 2'b01);
      repeat (3) @(negedge clk);
      ilv_en = 1'b1;
      cnt = 0;
      for (int n = 0; n < 16; n++) begin
         @(negedge clk);
         if (rx_oe !== (n < 8)) cnt++;
      end
      check(cnt, 0, "R7 master turn after enable");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule